// File: doc/BRIEF.md
# CAN Error-State Status Tracker

This block sits beside the error counters of a CAN controller. It turns the transmit and receive error counts into two 2-bit bus-state codes, one for the transmitter and one for the receiver. When the state those counts imply no longer matches the codes it reports, the block raises a status-change flag. The codes are registered and stay frozen while that flag is pending. Software therefore reads a consistent snapshot and then acknowledges it, and movement in the counters during that time cannot change the snapshot under it.

The bus-off condition is reported in both codes. When the transmit count goes above the bus-off limit, the receiver code also reads bus-off. When the transmitter later leaves bus-off, the receiver code drops straight to the OK code in the same update. After a later acknowledge it then picks up the band of the receive count. The flag is acknowledged with a write-one-to-clear strobe. A masked interrupt line follows the flag and an enable input.

Top module: `can_errstat_tracker`

## Requirements
- R1: The transmitter code follows the transmit count: 00 for 0..96, 01 for 97..127, 10 for 128..255 and 11 (bus-off) for 256 and above.
- R2: Outside bus-off, the receiver code follows the receive count: 00 for 0..96, 01 for 97..127 and 10 for 128 and above.
- R3: While the transmit count is above 255, the receiver code is 11 whatever the receive count is, so a reported 11 always appears in both codes together.
- R4: When the transmitter code leaves 11, the receiver code is set to 00 in that same update, whatever the receive count is.
- R5: When the state implied by the counters differs from the reported codes and no flag is pending, the codes take the new state and the flag sets at the next clock edge. The codes never change unless the flag is set with them.
- R6: While the flag is set and no clear is applied, the reported codes hold their value even when the counters enter another band.
- R7: The interrupt output is high exactly when the flag is set and the interrupt enable is high. It responds to the enable without a clock delay.
- R8: A clear strobe while the flag is set drops the flag at the next edge if the implied state then matches the reported codes. A clear strobe while the flag is clear has no effect.
- R9: During reset and just after it, both codes are 00, the flag is 0 and the interrupt is 0.
- R10: If a clear strobe arrives while the implied state differs from the held codes, the codes take the new state at the next edge and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_cnt | input | 9 | Transmit error count |
| rx_err_cnt | input | 8 | Receive error count |
| chg_irq_en | input | 1 | Enable for the status-change interrupt |
| chg_flag_clr | input | 1 | Write-one-to-clear strobe for the flag, one cycle wide |
| tx_state | output | 2 | Reported transmitter bus-state code |
| rx_state | output | 2 | Reported receiver bus-state code |
| chg_flag | output | 1 | Status-change flag |
| chg_irq | output | 1 | Masked status-change interrupt |

## Verification
The codes and the flag are registered, so they are due one clock edge after a counter value or a clear strobe is applied. The interrupt output is combinational from the flag and the enable, so it reflects the enable in the same cycle. The driver applies each stimulus on a falling edge. At the following rising edge it pushes the expected codes, flag and interrupt into a queue. The monitor pops and compares one time unit after that rising edge. Inputs stay steady from one falling edge to the next, so every comparison sees exactly one registered update and the enable that went with it.

// File: rtl/can_errstat_pkg.sv
package can_errstat_pkg;

    typedef enum logic [1:0] {
        BUS_OK      = 2'b00,
        BUS_WARN    = 2'b01,
        BUS_PASSIVE = 2'b10,
        BUS_OFF     = 2'b11
    } bus_state_e;

    typedef struct packed {
        bus_state_e tx;
        bus_state_e rx;
        logic       flag;
    } hold_state_t;

endpackage

// File: rtl/can_errstat_band.sv
// Maps one error count onto a bus-state band.
module can_errstat_band
    import can_errstat_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_MAX    = 96,
    parameter int PASSIVE_MAX = 127,
    parameter int OFF_MAX     = 255,
    parameter bit HAS_OFF     = 1'b1
) (
    input  logic [CNT_W-1:0] count,
    output bus_state_e       state
);

    localparam logic [CNT_W-1:0] WARN_L    = CNT_W'(WARN_MAX);
    localparam logic [CNT_W-1:0] PASSIVE_L = CNT_W'(PASSIVE_MAX);

    bus_state_e low_band;

    always_comb begin
        if (count > PASSIVE_L) begin
            low_band = BUS_PASSIVE;
        end else if (count > WARN_L) begin
            low_band = BUS_WARN;
        end else begin
            low_band = BUS_OK;
        end
    end

    generate
        if (HAS_OFF) begin : g_off
            localparam logic [CNT_W-1:0] OFF_L = CNT_W'(OFF_MAX);
            always_comb begin
                state = (count > OFF_L) ? BUS_OFF : low_band;
            end
        end else begin : g_no_off
            always_comb begin
                state = low_band;
            end
        end
    endgenerate

endmodule

// File: rtl/can_errstat_live.sv
// Computes the state implied by the live counters, with the bus-off mirror
// into the receiver code and the forced receiver OK code on bus-off exit.
module can_errstat_live
    import can_errstat_pkg::*;
#(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int WARN_MAX    = 96,
    parameter int PASSIVE_MAX = 127,
    parameter int OFF_MAX     = 255
) (
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    input  bus_state_e       rep_tx,
    output bus_state_e       live_tx,
    output bus_state_e       live_rx
);

    bus_state_e tx_band;
    bus_state_e rx_band;

    can_errstat_band #(
        .CNT_W      (TEC_W),
        .WARN_MAX   (WARN_MAX),
        .PASSIVE_MAX(PASSIVE_MAX),
        .OFF_MAX    (OFF_MAX),
        .HAS_OFF    (1'b1)
    ) u_tx_band (
        .count(tec),
        .state(tx_band)
    );

    can_errstat_band #(
        .CNT_W      (REC_W),
        .WARN_MAX   (WARN_MAX),
        .PASSIVE_MAX(PASSIVE_MAX),
        .OFF_MAX    (OFF_MAX),
        .HAS_OFF    (1'b0)
    ) u_rx_band (
        .count(rec),
        .state(rx_band)
    );

    logic leaving_off;

    always_comb begin
        live_tx     = tx_band;
        leaving_off = (rep_tx == BUS_OFF) && (tx_band != BUS_OFF);
        if (tx_band == BUS_OFF) begin
            live_rx = BUS_OFF;
        end else if (leaving_off) begin
            live_rx = BUS_OK;
        end else begin
            live_rx = rx_band;
        end
    end

endmodule

// File: rtl/can_errstat_hold.sv
// Holds the reported codes and the status-change flag.
module can_errstat_hold
    import can_errstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_state_e live_tx,
    input  bus_state_e live_rx,
    input  logic       clr,
    output bus_state_e rep_tx,
    output bus_state_e rep_rx,
    output logic       flag
);

    hold_state_t st_d;
    hold_state_t st_q;

    logic differs;
    logic pending;

    always_comb begin
        st_d    = st_q;
        differs = (live_tx != st_q.tx) || (live_rx != st_q.rx);
        pending = st_q.flag && !clr;
        if (!pending && differs) begin
            st_d.tx   = live_tx;
            st_d.rx   = live_rx;
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tx: BUS_OK, rx: BUS_OK, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rep_tx = st_q.tx;
    assign rep_rx = st_q.rx;
    assign flag   = st_q.flag;

endmodule

// File: rtl/can_errstat_tracker.sv
module can_errstat_tracker
    import can_errstat_pkg::*;
#(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int WARN_MAX    = 96,
    parameter int PASSIVE_MAX = 127,
    parameter int OFF_MAX     = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TEC_W-1:0] tx_err_cnt,
    input  logic [REC_W-1:0] rx_err_cnt,
    input  logic             chg_irq_en,
    input  logic             chg_flag_clr,
    output logic [1:0]       tx_state,
    output logic [1:0]       rx_state,
    output logic             chg_flag,
    output logic             chg_irq
);

    bus_state_e live_tx;
    bus_state_e live_rx;
    bus_state_e rep_tx;
    bus_state_e rep_rx;
    logic       flag_q;

    can_errstat_live #(
        .TEC_W      (TEC_W),
        .REC_W      (REC_W),
        .WARN_MAX   (WARN_MAX),
        .PASSIVE_MAX(PASSIVE_MAX),
        .OFF_MAX    (OFF_MAX)
    ) u_live (
        .tec    (tx_err_cnt),
        .rec    (rx_err_cnt),
        .rep_tx (rep_tx),
        .live_tx(live_tx),
        .live_rx(live_rx)
    );

    can_errstat_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .live_tx(live_tx),
        .live_rx(live_rx),
        .clr    (chg_flag_clr),
        .rep_tx (rep_tx),
        .rep_rx (rep_rx),
        .flag   (flag_q)
    );

    assign tx_state = rep_tx;
    assign rx_state = rep_rx;
    assign chg_flag = flag_q;
    assign chg_irq  = flag_q & chg_irq_en;

endmodule

// File: rtl/can_errstat_chk.sv
module can_errstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chg_irq_en,
    input logic       chg_flag_clr,
    input logic [1:0] tx_state,
    input logic [1:0] rx_state,
    input logic       chg_flag,
    input logic       chg_irq
);

    // R6
    hold_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !chg_flag_clr) |=> $stable({tx_state, rx_state}));

    // R5
    change_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({tx_state, rx_state}) |-> chg_flag);

    // R3
    busoff_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state == 2'b11) == (rx_state == 2'b11));

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq |-> (chg_flag && chg_irq_en));

    // R7
    irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && chg_irq_en) |-> chg_irq);

    // R8
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && chg_flag_clr) |=> (!chg_flag || !$stable({tx_state, rx_state})));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!chg_flag && !chg_irq && tx_state == 2'b00 && rx_state == 2'b00));

endmodule

bind can_errstat_tracker can_errstat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_irq_en  (chg_irq_en),
    .chg_flag_clr(chg_flag_clr),
    .tx_state    (tx_state),
    .rx_state    (rx_state),
    .chg_flag    (chg_flag),
    .chg_irq     (chg_irq)
);

// File: tb/test_can_errstat_tracker.sv
`timescale 1ns/1ps
module test_can_errstat_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tec = '0;
    logic [7:0] rec = '0;
    logic       en = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] tx_state;
    logic [1:0] rx_state;
    logic       chg_flag;
    logic       chg_irq;

    always #2 clk = ~clk;

    can_errstat_tracker i_can_errstat_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_err_cnt  (tec),
        .rx_err_cnt  (rec),
        .chg_irq_en  (en),
        .chg_flag_clr(clr),
        .tx_state    (tx_state),
        .rx_state    (rx_state),
        .chg_flag    (chg_flag),
        .chg_irq     (chg_irq)
    );

    typedef struct {
        logic [1:0] tx;
        logic [1:0] rx;
        logic       flag;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    logic [1:0] m_tx = 2'b00;
    logic [1:0] m_rx = 2'b00;
    logic       m_flag = 1'b0;

    function automatic logic [1:0] band(input int v, input bit off_ok);
        if (off_ok && v > 255) return 2'b11;
        if (v > 127) return 2'b10;
        if (v > 96)  return 2'b01;
        return 2'b00;
    endfunction

    // Drive one cycle of stimulus, then queue the expected registered result.
    task automatic step(input int t, input int r, input bit e, input bit c, input string tag);
        logic [1:0] ltx;
        logic [1:0] lrx;
        exp_t it;
        @(negedge clk);
        tec = t[8:0];
        rec = r[7:0];
        en  = e;
        clr = c;
        @(posedge clk);
        ltx = band(t, 1'b1);
        if (ltx == 2'b11)                        lrx = 2'b11;
        else if (m_tx == 2'b11)                  lrx = 2'b00;
        else                                     lrx = band(r, 1'b0);
        if (!(m_flag && !c) && (ltx != m_tx || lrx != m_rx)) begin
            m_tx = ltx;
            m_rx = lrx;
            m_flag = 1'b1;
        end else if (c) begin
            m_flag = 1'b0;
        end
        it.tx = m_tx;
        it.rx = m_rx;
        it.flag = m_flag;
        it.irq = m_flag & e;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compares one time unit after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                n_run++;
                if (tx_state !== it.tx || rx_state !== it.rx ||
                    chg_flag !== it.flag || chg_irq !== it.irq) begin
                    n_fail++;
                    $display("FAIL %s: got tx=%b rx=%b flag=%b irq=%b, expected tx=%b rx=%b flag=%b irq=%b",
                             it.tag, tx_state, rx_state, chg_flag, chg_irq,
                             it.tx, it.rx, it.flag, it.irq);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (tx_state !== 2'b00 || rx_state !== 2'b00 || chg_flag !== 1'b0 || chg_irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset: got tx=%b rx=%b flag=%b irq=%b, expected 00 00 0 0",
                     tx_state, rx_state, chg_flag, chg_irq);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step(50, 50, 0, 0, "R9 quiet after reset");
        step(96, 96, 1, 0, "R1 R2 upper edge of OK band");
        step(97, 50, 0, 0, "R1 tx warn band sets flag R5");
        step(97, 50, 1, 0, "R7 irq follows enable");
        step(130, 50, 1, 0, "R6 codes frozen while pending");
        step(130, 50, 0, 0, "R7 enable low masks irq");
        step(130, 50, 1, 1, "R10 clear with pending difference");
        step(130, 50, 1, 1, "R8 clear drops flag");
        step(130, 50, 1, 1, "R8 clear with flag low is ignored");
        step(255, 97, 0, 0, "R2 rx warn band, tx 255 stays passive R1");
        step(255, 97, 0, 1, "R8 clear");
        step(255, 128, 0, 0, "R2 rx passive band");
        step(255, 128, 0, 1, "R8 clear");
        step(256, 20, 1, 0, "R3 bus-off mirrored into rx");
        step(300, 200, 1, 1, "R3 clear in bus-off");
        step(0, 110, 1, 0, "R4 leaving bus-off forces rx 00");
        step(0, 110, 1, 1, "R10 rx picks up warn band on clear");
        step(0, 110, 1, 1, "R8 clear settles");
        step(127, 127, 0, 0, "R1 R2 upper edge of warn band");
        step(127, 127, 0, 1, "R8 clear");
        step(128, 127, 0, 0, "R1 lower edge of passive band");
        step(128, 0, 0, 1, "R10 rx returns to OK on clear");
        step(128, 0, 0, 1, "R8 final clear");
        step(128, 0, 0, 0, "R5 no difference keeps flag low");
        @(negedge clk);
        clr = 1'b0;
        @(posedge clk);
        #2;
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule